// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block sits behind three address/data comparators and decides when a debug trigger fires. It moves through three intermediate states toward a terminal trigger state. Each step follows the comparator match pulses it receives. Each intermediate state owns a configuration slot holding two exit rules. A rule pairs a target state with a channel mask, and it fires when any channel selected by that mask matches. With two rules per state and masks that OR several channels, one state can fork. It can continue an expected execution order on one channel and abort to the trigger on any other. This lets the block catch loops that run out of order, repeated events, and "event C before event B after event A" patterns.

Software loads the three slots while the sequencer is idle, then pulses `arm`. From then on the sequencer runs from the first state. When it reaches the trigger state it emits a single-cycle pulse and keeps a sticky flag set. It stays there until software re-arms it or clears it.

Top module: `dbg_seq_top`

## Requirements
- R1: After synchronous active-low reset, `state` is 0 (first state), `armed`, `trig_pulse` and `trig_sticky` are 0, and all three configuration slots read back as zero.
- R2: A write with `cfg_we` high while `armed` is low stores `cfg_wdata` in slot `cfg_addr` (0, 1, 2 = first, second, third state); `cfg_rdata` continuously shows the slot selected by `cfg_addr`, and address 3 reads zero.
- R3: A configuration write presented while `armed` is high changes no slot.
- R4: Slot bits [4:0] are rule 0 and bits [9:5] are rule 1; in a rule, bits [2:0] are a channel mask (bit i selects `match[i]`) and bits [4:3] are the target state (0, 1, 2 = intermediate states, 3 = trigger state). A rule fires when any masked channel matches, and a zero mask never fires.
- R5: When both rules of the current state fire in the same cycle, rule 0's target is taken.
- R6: While armed and not in the trigger state, with neither rule firing, the state holds; at most one transition occurs per clock.
- R7: `trig_pulse` is high for exactly the one cycle in which `state` first reads 3, and `trig_sticky` rises in that same cycle.
- R8: Once in state 3, the state and `trig_sticky` hold whatever the match inputs do, until `arm` or `clear`.
- R9: `arm` sets `armed`, returns the state to 0 and clears `trig_sticky` on the next cycle, and it overrides any match in the same cycle.
- R10: `clear` drops `armed`, returns the state to 0 and clears `trig_sticky`, and it takes priority over `arm`; while disarmed, match inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Slot select for write and readback |
| cfg_wdata | input | 10 | Slot write data (two exit rules) |
| cfg_rdata | output | 10 | Contents of the selected slot |
| arm | input | 1 | Start sequencing from the first state |
| clear | input | 1 | Disarm and reset the sequencer |
| match | input | 3 | Comparator match pulses, bit i is channel i |
| state | output | 2 | Current sequencer state |
| armed | output | 1 | Sequencer is running or holding a trigger |
| trig_pulse | output | 1 | One-cycle pulse on entry to the trigger state |
| trig_sticky | output | 1 | Trigger reached since the last arm or clear |

## Verification
Two things can fall in the same cycle. The two exit rules of one state can both fire on a single match vector, and an `arm` or `clear` can coincide with a match that would otherwise move the state. The bench provokes the first by giving both rules overlapping masks with different targets. It provokes the second by raising `arm` in the same cycle as a firing match, and `clear` in the same cycle as `arm`. A reference model in the bench applies the stated priorities: clear over arm over match, and rule 0 over rule 1. The state, pulse and sticky flag are compared against that model every cycle, both in these directed cases and in long random runs where such collisions occur freely.

// File: rtl/dbg_seq_pkg.sv
// Shared encodings for the debug trigger sequencer.
// Assumes three comparator channels and a two-bit state code whose top value
// is the terminal trigger state.
package dbg_seq_pkg;
    localparam int SEQ_CH     = 3;                     // comparator channels
    localparam int SEQ_ST_W   = 2;                     // state code width
    localparam int SEQ_NMID   = 3;                     // intermediate states
    localparam int SEQ_NRULE  = 2;                     // exit rules per state
    localparam int SEQ_RULE_W = SEQ_CH + SEQ_ST_W;     // mask + target
    localparam int SEQ_SLOT_W = SEQ_RULE_W * SEQ_NRULE;

    typedef enum logic [SEQ_ST_W-1:0] {
        SQ_ONE   = 2'd0,
        SQ_TWO   = 2'd1,
        SQ_THREE = 2'd2,
        SQ_FINAL = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [SEQ_ST_W-1:0] tgt;   // bits [4:3]
        logic [SEQ_CH-1:0]   mask;  // bits [2:0]
    } exit_rule_t;
endpackage

// File: rtl/dbg_seq_cfg.sv
// Configuration bank: one slot per intermediate state, each holding the
// exit rules of that state. Writes are accepted only when not locked.
// Assumes addresses at or above NSLOT are unmapped and read as zero.
module dbg_seq_cfg #(
    parameter int NSLOT  = 3,
    parameter int SLOT_W = 10,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    lock,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [SLOT_W-1:0]       wdata,
    output logic [NSLOT*SLOT_W-1:0] slots,
    output logic [SLOT_W-1:0]       rdata
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [SLOT_W-1:0] q;
        // Slot register: capture write data when addressed and unlocked.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && !lock && addr == ADDR_W'(g))
                q <= wdata;
        end
        assign slots[g*SLOT_W +: SLOT_W] = q;
    end

    // Readback mux over the mapped slots.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++)
            if (addr == ADDR_W'(i))
                rdata = slots[i*SLOT_W +: SLOT_W];
    end
endmodule

// File: rtl/dbg_seq_rule.sv
// Single exit rule evaluator: fires when any channel selected by the rule's
// mask is matching. Assumes a zero mask means the rule is disabled.
module dbg_seq_rule
    import dbg_seq_pkg::*;
(
    input  exit_rule_t        rule,
    input  logic [SEQ_CH-1:0] match,
    output logic              hit
);
    // OR of the masked channels.
    assign hit = |(rule.mask & match);
endmodule

// File: rtl/dbg_seq_arb.sv
// Transition arbiter: picks the slot of the current state, evaluates its
// rules and resolves them by fixed priority (lower rule index wins).
// Assumes the caller ignores the result while in the terminal state.
module dbg_seq_arb
    import dbg_seq_pkg::*;
#(
    parameter int NSLOT  = SEQ_NMID,
    parameter int NRULE  = SEQ_NRULE,
    parameter int SLOT_W = SEQ_SLOT_W
) (
    input  logic [NSLOT*SLOT_W-1:0] slots,
    input  seq_state_e              cur,
    input  logic [SEQ_CH-1:0]       match,
    output logic                    take,
    output seq_state_e              nxt
);
    logic [SLOT_W-1:0] sel;
    logic [NRULE-1:0]  hits;
    exit_rule_t        rules [NRULE];

    // Slot select by current state; the terminal state sees an empty slot.
    always_comb begin
        sel = '0;
        for (int i = 0; i < NSLOT; i++)
            if (cur == seq_state_e'(i))
                sel = slots[i*SLOT_W +: SLOT_W];
    end

    for (genvar r = 0; r < NRULE; r++) begin : g_rule
        assign rules[r] = exit_rule_t'(sel[r*SEQ_RULE_W +: SEQ_RULE_W]);
        dbg_seq_rule u_rule (
            .rule  (rules[r]),
            .match (match),
            .hit   (hits[r])
        );
    end

    // Priority resolve: scan from the highest index down so rule 0 wins.
    always_comb begin
        take = 1'b0;
        nxt  = cur;
        for (int r = NRULE - 1; r >= 0; r--)
            if (hits[r]) begin
                take = 1'b1;
                nxt  = seq_state_e'(rules[r].tgt);
            end
    end
endmodule

// File: rtl/dbg_seq_top.sv
// Debug trigger sequencer top: configuration bank, transition arbiter and
// the state/trigger registers. Clear beats arm, arm beats any match.
// Assumes match inputs are synchronous single-cycle comparator pulses.
module dbg_seq_top
    import dbg_seq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [SEQ_SLOT_W-1:0] cfg_wdata,
    output logic [SEQ_SLOT_W-1:0] cfg_rdata,
    input  logic                  arm,
    input  logic                  clear,
    input  logic [SEQ_CH-1:0]     match,
    output logic [SEQ_ST_W-1:0]   state,
    output logic                  armed,
    output logic                  trig_pulse,
    output logic                  trig_sticky
);
    localparam int FLAT_W = SEQ_NMID * SEQ_SLOT_W;

    logic [FLAT_W-1:0] cfg_flat;
    seq_state_e        cur_q;
    seq_state_e        nxt;
    logic              take;
    logic              armed_q;
    logic              pulse_q;
    logic              sticky_q;

    dbg_seq_cfg #(
        .NSLOT  (SEQ_NMID),
        .SLOT_W (SEQ_SLOT_W),
        .ADDR_W (ADDR_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .lock  (armed_q),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .slots (cfg_flat),
        .rdata (cfg_rdata)
    );

    dbg_seq_arb #(
        .NSLOT  (SEQ_NMID),
        .NRULE  (SEQ_NRULE),
        .SLOT_W (SEQ_SLOT_W)
    ) u_arb (
        .slots (cfg_flat),
        .cur   (cur_q),
        .match (match),
        .take  (take),
        .nxt   (nxt)
    );

    // Sequencer registers: control priority, one transition per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= SQ_ONE;
            armed_q  <= 1'b0;
            pulse_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (clear) begin
                cur_q    <= SQ_ONE;
                armed_q  <= 1'b0;
                sticky_q <= 1'b0;
            end else if (arm) begin
                cur_q    <= SQ_ONE;
                armed_q  <= 1'b1;
                sticky_q <= 1'b0;
            end else if (armed_q && cur_q != SQ_FINAL && take) begin
                cur_q <= nxt;
                if (nxt == SQ_FINAL) begin
                    pulse_q  <= 1'b1;
                    sticky_q <= 1'b1;
                end
            end
        end
    end

    assign state       = cur_q;
    assign armed       = armed_q;
    assign trig_pulse  = pulse_q;
    assign trig_sticky = sticky_q;
endmodule

// File: rtl/dbg_seq_chk.sv
// Property checker for the trigger sequencer, bound into the top module.
// Assumes it observes the top's ports plus the flattened configuration.
module dbg_seq_chk #(
    parameter int FLAT_W = 30
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              clear,
    input logic [2:0]        match,
    input logic [1:0]        state,
    input logic              armed,
    input logic              trig_pulse,
    input logic              trig_sticky,
    input logic [FLAT_W-1:0] cfg_flat
);
    assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> $stable(cfg_flat));

    assert_hold_no_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm && !clear && match == 3'b000) |=> $stable(state));

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    assert_pulse_final_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (trig_sticky && state == 2'd3));

    assert_final_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && !arm && !clear) |=> (state == 2'd3 && trig_sticky));

    assert_arm_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !clear) |=> (armed && state == 2'd0 && !trig_sticky));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!armed && state == 2'd0 && !trig_sticky));

    assert_idle_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm) |=> (state == 2'd0 && !trig_pulse));
endmodule

bind dbg_seq_top dbg_seq_chk #(.FLAT_W(FLAT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .clear       (clear),
    .match       (match),
    .state       (state),
    .armed       (armed),
    .trig_pulse  (trig_pulse),
    .trig_sticky (trig_sticky),
    .cfg_flat    (cfg_flat)
);

// File: tb/tb_dbg_seq_top.sv
// Self-checking bench: directed scenarios plus seeded random traffic,
// compared each cycle against a reference model built from the requirements.
module tb_dbg_seq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [9:0] cfg_wdata = '0;
    logic [9:0] cfg_rdata;
    logic       arm = 1'b0;
    logic       clear = 1'b0;
    logic [2:0] match = '0;
    logic [1:0] state;
    logic       armed, trig_pulse, trig_sticky;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [9:0] m_cfg [3];
    logic [1:0] m_st;
    logic       m_armed, m_pulse, m_sticky;

    always #4 clk = ~clk;

    dbg_seq_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .arm(arm), .clear(clear),
        .match(match), .state(state), .armed(armed), .trig_pulse(trig_pulse),
        .trig_sticky(trig_sticky)
    );

    function automatic logic [4:0] rule(input logic [1:0] tgt, input logic [2:0] mask);
        return {tgt, mask};
    endfunction

    function automatic logic [1:0] model_next(input logic [9:0] slot,
                                              input logic [1:0] st, input logic [2:0] m);
        if (|(slot[2:0] & m)) return slot[4:3];
        if (|(slot[7:5] & m)) return slot[9:8];
        return st;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic [9:0] exp_rd;
        exp_rd = (cfg_addr < 2'd3) ? m_cfg[cfg_addr] : 10'd0;
        chk(tag, "state", int'(state), int'(m_st));
        chk(tag, "trig_pulse", int'(trig_pulse), int'(m_pulse));
        chk(tag, "trig_sticky", int'(trig_sticky), int'(m_sticky));
        chk(tag, "armed", int'(armed), int'(m_armed));
        chk(tag, "cfg_rdata", int'(cfg_rdata), int'(exp_rd));
    endtask

    // One clock: apply inputs, advance the model with them, compare after.
    task automatic step(input string tag, input logic a, input logic c, input logic we,
                        input logic [1:0] ad, input logic [9:0] wd, input logic [2:0] m);
        logic [1:0] n;
        arm = a; clear = c; cfg_we = we; cfg_addr = ad; cfg_wdata = wd; match = m;
        @(posedge clk);
        if (we && !m_armed && ad < 2'd3) m_cfg[ad] = wd;
        m_pulse = 1'b0;
        if (c) begin
            m_armed = 1'b0; m_st = 2'd0; m_sticky = 1'b0;
        end else if (a) begin
            m_armed = 1'b1; m_st = 2'd0; m_sticky = 1'b0;
        end else if (m_armed && m_st != 2'd3) begin
            n = model_next(m_cfg[m_st], m_st, m);
            if (n == 2'd3 && n != m_st) begin
                m_pulse = 1'b1; m_sticky = 1'b1;
            end
            m_st = n;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        compare(tag);
    endtask

    task automatic wr(input string tag, input logic [1:0] ad, input logic [9:0] wd);
        step(tag, 1'b0, 1'b0, 1'b1, ad, wd, 3'b000);
    endtask

    task automatic idle(input string tag, input logic [2:0] m);
        step(tag, 1'b0, 1'b0, 1'b0, 2'd0, 10'd0, m);
    endtask

    task automatic do_arm(input string tag);
        step(tag, 1'b1, 1'b0, 1'b0, 2'd0, 10'd0, 3'b000);
    endtask

    task automatic do_clear(input string tag);
        step(tag, 1'b0, 1'b1, 1'b0, 2'd0, 10'd0, 3'b000);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EC0_0D1E));
        for (int i = 0; i < 3; i++) m_cfg[i] = '0;
        m_st = 2'd0; m_armed = 1'b0; m_pulse = 1'b0; m_sticky = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and empty slots
        for (int a = 0; a < 4; a++) begin
            cfg_addr = 2'(a);
            #1;
            compare("R1");
        end

        // R2: writes while idle, readback of each slot and unmapped address
        wr("R2", 2'd0, 10'h2A5);
        wr("R2", 2'd1, 10'h15A);
        wr("R2", 2'd3, 10'h3FF);
        for (int a = 0; a < 4; a++) step("R2", 1'b0, 1'b0, 1'b0, 2'(a), 10'd0, 3'b000);

        // R4/R6: all masks zero, matches never move the state
        wr("R4", 2'd0, 10'd0); wr("R4", 2'd1, 10'd0); wr("R4", 2'd2, 10'd0);
        do_arm("R9");
        idle("R4", 3'b111); idle("R6", 3'b010);

        // R4: out-of-order loop check (order M1, M2, M0, anything else triggers)
        do_clear("R10");
        wr("R4", 2'd0, {rule(2'd3, 3'b101), rule(2'd1, 3'b010)});
        wr("R4", 2'd1, {rule(2'd3, 3'b011), rule(2'd2, 3'b100)});
        wr("R4", 2'd2, {rule(2'd3, 3'b110), rule(2'd0, 3'b001)});
        do_arm("R9");
        idle("R4", 3'b010); idle("R6", 3'b000); idle("R4", 3'b100);
        idle("R4", 3'b001); idle("R4", 3'b010); idle("R4", 3'b100);
        idle("R7", 3'b010);
        idle("R7", 3'b000);
        // R8: final holds under all matches
        idle("R8", 3'b111); idle("R8", 3'b001); idle("R8", 3'b100);
        // R3: writes while armed (including in final) are dropped
        wr("R3", 2'd0, 10'h3FF); wr("R3", 2'd2, 10'h000);
        step("R3", 1'b0, 1'b0, 1'b0, 2'd0, 10'd0, 3'b000);
        step("R3", 1'b0, 1'b0, 1'b0, 2'd2, 10'd0, 3'b000);

        // R9: arm overrides a firing match in the same cycle
        do_arm("R9");
        step("R9", 1'b1, 1'b0, 1'b0, 2'd0, 10'd0, 3'b010);
        // R10: clear beats arm; disarmed ignores matches
        step("R10", 1'b1, 1'b1, 1'b0, 2'd0, 10'd0, 3'b010);
        idle("R10", 3'b111); idle("R10", 3'b101);

        // M0 twice before M1/M2
        wr("R4", 2'd0, {rule(2'd0, 3'b000), rule(2'd2, 3'b001)});
        wr("R4", 2'd2, {rule(2'd0, 3'b110), rule(2'd3, 3'b001)});
        do_arm("R9");
        idle("R4", 3'b001); idle("R4", 3'b100); idle("R4", 3'b001);
        idle("R4", 3'b001); idle("R7", 3'b000);

        // R5: both rules fire, rule 0 wins
        do_clear("R10");
        wr("R5", 2'd0, {rule(2'd2, 3'b011), rule(2'd1, 3'b001)});
        wr("R5", 2'd1, {rule(2'd3, 3'b100), rule(2'd0, 3'b100)});
        do_arm("R9");
        idle("R5", 3'b001);
        idle("R5", 3'b100);
        idle("R6", 3'b011);

        // Random traffic with collisions among arm, clear, writes and matches
        for (int it = 0; it < 400; it++) begin
            do_clear("R10");
            for (int s = 0; s < 3; s++) wr("R2", 2'(s), 10'($urandom));
            do_arm("R9");
            for (int c = 0; c < 30; c++) begin
                logic [2:0] m;
                int r;
                r = int'($urandom_range(0, 99));
                m = ($urandom_range(0, 2) == 0) ? 3'b000 : 3'($urandom);
                step("R6", r < 3, r >= 97, r >= 90, 2'($urandom), 10'($urandom), m);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule